// File: doc/BRIEF.md
# Multicycle Shared-Port Processor Datapath

This block is the datapath half of a 32-bit load/store processor that spends several clock cycles on each instruction. A single memory port carries both instruction fetches and load/store traffic. A single adder-based ALU is reused for the next sequential PC, the branch target, effective addresses and register arithmetic. Values computed in one cycle are held for the next in internal holding registers: instruction word, memory data, two operand registers and an ALU result register.

The block contains no sequencing. An external controller drives every multiplexer select and write enable on each cycle. The block gives back the opcode of the held instruction, the live ALU zero flag and the live signed-overflow flag. It also keeps an exception return address register and a one-bit cause register. The PC can be loaded from four sources: the live ALU result, the held ALU result, a jump target built from the instruction, or a fixed exception vector.

Instruction fields used: opcode IR[31:26], first source IR[25:21], second source/load destination IR[20:16], arithmetic destination IR[15:11], function IR[5:0], immediate IR[15:0], jump target IR[25:0]. The register file has REG_CNT entries. Each register number is taken from the low bits of its five-bit field.

Top module: `mc_datapath`

## Requirements
- R1: While reset is asserted and after it is released, PC, IR, EPC and Cause hold zero, so the memory address shows 0 and the opcode output is 000000.
- R2: The memory address is the PC when ctl_iord=0 and the held ALU result when ctl_iord=1. The memory read and write enables follow ctl_mem_rd and ctl_mem_wr.
- R3: The PC changes at an edge only when ctl_pc_we=1, or when ctl_pc_we_cond=1 and the ALU zero flag is 1. With ctl_pc_sel=00 it takes the live ALU result, so PC+4 is formed by ctl_srca=0, ctl_srcb=01, ctl_aluop=00.
- R4: With ctl_pc_sel=01 the PC takes the held ALU result. A decode cycle with ctl_srca=0, ctl_srcb=11 holds PC plus the sign-extended IR[15:0] shifted left by 2, so a conditional write implements a taken/not-taken equality branch.
- R5: With ctl_pc_sel=10 the PC becomes {PC[31:28], IR[25:0], 2'b00}.
- R6: With ctl_pc_sel=11 the PC becomes 0xC000_0000. On ctl_epc_we the EPC loads the live ALU result. On ctl_cause_we the Cause register becomes {31'b0, int_cause}, where 0 means undefined instruction and 1 means arithmetic overflow.
- R7: IR loads the memory read data only on an edge with ctl_ir_we=1. The opcode output is always IR[31:26].
- R8: The register write address is IR[20:16] when ctl_rf_dst=0 and IR[15:11] when ctl_rf_dst=1. The write data is the held ALU result when ctl_rf_src=0 and the memory data register when ctl_rf_src=1. Store data is the B register, which is loaded every cycle from the register addressed by IR[20:16].
- R9: ctl_aluop=00 adds and 01 subtracts. With 10 the function field selects the operation: 100000 add, 100010 subtract, 100100 AND, 100101 OR, 101010 signed set-less-than. Any other function code gives a result of 0.
- R10: alu_ovf reports signed two's-complement overflow only for add and subtract operations. alu_zero is 1 exactly when the live ALU result is 0.
- R11: Register 0 always reads as zero, and writes to it have no effect.
- R12: ctl_srca selects PC (0) or A (1) as the first operand. ctl_srcb selects B (00), the constant 4 (01), the sign-extended IR[15:0] (10), or that value shifted left by 2 (11).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserted asynchronously, released in step with clk |
| ctl_iord | input | 1 | Memory address select: 0 PC, 1 held ALU result |
| ctl_mem_rd | input | 1 | Memory read request |
| ctl_mem_wr | input | 1 | Memory write request |
| ctl_ir_we | input | 1 | Instruction register load enable |
| ctl_pc_we | input | 1 | Unconditional PC write |
| ctl_pc_we_cond | input | 1 | PC write when the ALU zero flag is set |
| ctl_rf_we | input | 1 | Register file write enable |
| ctl_rf_dst | input | 1 | Write address select: 0 IR[20:16], 1 IR[15:11] |
| ctl_rf_src | input | 1 | Write data select: 0 held ALU result, 1 memory data register |
| ctl_srca | input | 1 | First ALU operand: 0 PC, 1 A |
| ctl_srcb | input | 2 | Second ALU operand select |
| ctl_aluop | input | 2 | ALU operation class |
| ctl_pc_sel | input | 2 | Next PC source |
| ctl_epc_we | input | 1 | EPC load enable |
| ctl_cause_we | input | 1 | Cause load enable |
| int_cause | input | 1 | Cause code: 0 undefined instruction, 1 overflow |
| mem_rdata | input | 32 | Memory read data |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data (B register) |
| mem_rd_en | output | 1 | Memory read enable |
| mem_wr_en | output | 1 | Memory write enable |
| opcode | output | 6 | IR[31:26] to the controller |
| alu_zero | output | 1 | Live ALU result is zero |
| alu_ovf | output | 1 | Live signed overflow of add/subtract |
| epc | output | 32 | Exception return address |
| cause | output | 32 | Cause register |

## Verification
A corrupt PC shows at mem_addr on the very next fetch cycle. A wrong IR shows on the opcode port one cycle after the load edge. A bad register file write or holding register only appears where a later instruction routes it out: an operand read back through the store data port, or an effective address on mem_addr. That takes two to four cycles. The bench therefore runs full fetch–decode–execute sequences and observes each result through a store, a memory address or a branch outcome. The ALU flags are combinational and are sampled in the same execute cycle.

// File: rtl/mc_dp_pkg.sv
package mc_dp_pkg;

  localparam int XLEN = 32;

  // operand B select codes
  localparam logic [1:0] SRCB_REG   = 2'b00;
  localparam logic [1:0] SRCB_FOUR  = 2'b01;
  localparam logic [1:0] SRCB_IMM   = 2'b10;
  localparam logic [1:0] SRCB_IMMSH = 2'b11;

  // next PC select codes
  localparam logic [1:0] PCS_ALU  = 2'b00;
  localparam logic [1:0] PCS_HELD = 2'b01;
  localparam logic [1:0] PCS_JUMP = 2'b10;
  localparam logic [1:0] PCS_EXC  = 2'b11;

  // ALU operation class from the controller
  localparam logic [1:0] AOP_ADD  = 2'b00;
  localparam logic [1:0] AOP_SUB  = 2'b01;
  localparam logic [1:0] AOP_FUNC = 2'b10;

  // function field codes
  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR,
    ALU_SLT,
    ALU_NONE
  } alu_fn_e;

endpackage

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int REG_CNT = 8,
  parameter int DW      = 32,
  localparam int RA_W   = $clog2(REG_CNT)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RA_W-1:0] ra1,
  input  logic [RA_W-1:0] ra2,
  output logic [DW-1:0]   rd1,
  output logic [DW-1:0]   rd2,
  input  logic            we,
  input  logic [RA_W-1:0] wa,
  input  logic [DW-1:0]   wd
);

  logic [REG_CNT-1:0][DW-1:0] rd_arr;

  // entry 0 has no storage: constant zero
  assign rd_arr[0] = '0;

  for (genvar gi = 1; gi < REG_CNT; gi++) begin : g_reg
    logic          hit;
    logic [DW-1:0] q;
    logic [DW-1:0] d;

    assign hit = we && (wa == RA_W'(gi));

    always_comb begin
      d = q;
      if (hit) d = wd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end

    assign rd_arr[gi] = q;
  end

  assign rd1 = rd_arr[ra1];
  assign rd2 = rd_arr[ra2];

endmodule

// File: rtl/mc_alu_dec.sv
module mc_alu_dec
  import mc_dp_pkg::*;
(
  input  logic [1:0] aluop,
  input  logic [5:0] funct,
  output alu_fn_e    fn
);

  always_comb begin
    fn = ALU_ADD;
    case (aluop)
      AOP_ADD: fn = ALU_ADD;
      AOP_SUB: fn = ALU_SUB;
      AOP_FUNC: begin
        case (funct)
          FN_ADD:  fn = ALU_ADD;
          FN_SUB:  fn = ALU_SUB;
          FN_AND:  fn = ALU_AND;
          FN_OR:   fn = ALU_OR;
          FN_SLT:  fn = ALU_SLT;
          default: fn = ALU_NONE;
        endcase
      end
      default: fn = ALU_ADD;
    endcase
  end

endmodule

// File: rtl/mc_alu.sv
module mc_alu
  import mc_dp_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  alu_fn_e       fn,
  output logic [DW-1:0] y,
  output logic          zero,
  output logic          ovf
);

  logic          use_sub;
  logic [DW-1:0] b_eff;
  logic [DW-1:0] sum;
  logic          lt;
  logic          arith;

  // subtract and compare share the inverted-operand adder
  assign use_sub = (fn == ALU_SUB) || (fn == ALU_SLT);
  assign b_eff   = use_sub ? ~b : b;
  assign sum     = a + b_eff + DW'(use_sub);
  assign lt      = $signed(a) < $signed(b);
  assign arith   = (fn == ALU_ADD) || (fn == ALU_SUB);

  always_comb begin
    case (fn)
      ALU_ADD, ALU_SUB: y = sum;
      ALU_AND:          y = a & b;
      ALU_OR:           y = a | b;
      ALU_SLT:          y = DW'(lt);
      default:          y = '0;
    endcase
  end

  assign zero = (y == '0);
  assign ovf  = arith && (a[DW-1] == b_eff[DW-1]) && (sum[DW-1] != a[DW-1]);

endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mc_dp_pkg::*;
#(
  parameter int          REG_CNT    = 8,
  parameter logic [31:0] EXC_VECTOR = 32'hC000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_iord,
  input  logic        ctl_mem_rd,
  input  logic        ctl_mem_wr,
  input  logic        ctl_ir_we,
  input  logic        ctl_pc_we,
  input  logic        ctl_pc_we_cond,
  input  logic        ctl_rf_we,
  input  logic        ctl_rf_dst,
  input  logic        ctl_rf_src,
  input  logic        ctl_srca,
  input  logic [1:0]  ctl_srcb,
  input  logic [1:0]  ctl_aluop,
  input  logic [1:0]  ctl_pc_sel,
  input  logic        ctl_epc_we,
  input  logic        ctl_cause_we,
  input  logic        int_cause,
  input  logic [31:0] mem_rdata,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic        mem_rd_en,
  output logic        mem_wr_en,
  output logic [5:0]  opcode,
  output logic        alu_zero,
  output logic        alu_ovf,
  output logic [31:0] epc,
  output logic [31:0] cause
);

  localparam int DW   = XLEN;
  localparam int RA_W = $clog2(REG_CNT);

  // architectural and holding registers
  logic [DW-1:0] pc_q, pc_d;
  logic [DW-1:0] ir_q, ir_d;
  logic [DW-1:0] mdr_q, mdr_d;
  logic [DW-1:0] a_q, a_d;
  logic [DW-1:0] b_q, b_d;
  logic [DW-1:0] held_q, held_d;
  logic [DW-1:0] epc_q, epc_d;
  logic          cause_q, cause_d;

  logic [DW-1:0] rf_rd1, rf_rd2, rf_wd;
  logic [RA_W-1:0] rf_wa;
  logic [DW-1:0] imm_sx, op_a, op_b, alu_y, pc_next;
  logic          pc_load;
  alu_fn_e       alu_fn;

  // ---------------- field extraction and operand muxes ----------------
  assign imm_sx = {{(DW-16){ir_q[15]}}, ir_q[15:0]};

  always_comb begin
    op_a = ctl_srca ? a_q : pc_q;
  end

  always_comb begin
    case (ctl_srcb)
      SRCB_REG:   op_b = b_q;
      SRCB_FOUR:  op_b = DW'(4);
      SRCB_IMM:   op_b = imm_sx;
      default:    op_b = {imm_sx[DW-3:0], 2'b00};
    endcase
  end

  // ---------------- ALU ----------------
  mc_alu_dec u_alu_dec (
    .aluop (ctl_aluop),
    .funct (ir_q[5:0]),
    .fn    (alu_fn)
  );

  mc_alu #(.DW(DW)) u_alu (
    .a    (op_a),
    .b    (op_b),
    .fn   (alu_fn),
    .y    (alu_y),
    .zero (alu_zero),
    .ovf  (alu_ovf)
  );

  // ---------------- register file ----------------
  assign rf_wa = ctl_rf_dst ? ir_q[11 +: RA_W] : ir_q[16 +: RA_W];
  assign rf_wd = ctl_rf_src ? mdr_q : held_q;

  mc_regfile #(.REG_CNT(REG_CNT), .DW(DW)) u_regfile (
    .clk   (clk),
    .rst_n (rst_n),
    .ra1   (ir_q[21 +: RA_W]),
    .ra2   (ir_q[16 +: RA_W]),
    .rd1   (rf_rd1),
    .rd2   (rf_rd2),
    .we    (ctl_rf_we),
    .wa    (rf_wa),
    .wd    (rf_wd)
  );

  // ---------------- next PC ----------------
  always_comb begin
    case (ctl_pc_sel)
      PCS_ALU:  pc_next = alu_y;
      PCS_HELD: pc_next = held_q;
      PCS_JUMP: pc_next = {pc_q[DW-1:28], ir_q[25:0], 2'b00};
      default:  pc_next = EXC_VECTOR;
    endcase
  end

  assign pc_load = ctl_pc_we || (ctl_pc_we_cond && alu_zero);

  // ---------------- next-state logic ----------------
  always_comb begin
    pc_d    = pc_q;
    ir_d    = ir_q;
    epc_d   = epc_q;
    cause_d = cause_q;
    if (pc_load)      pc_d    = pc_next;
    if (ctl_ir_we)    ir_d    = mem_rdata;
    if (ctl_epc_we)   epc_d   = alu_y;
    if (ctl_cause_we) cause_d = int_cause;
  end

  // holding registers refresh on every edge
  always_comb begin
    mdr_d  = mem_rdata;
    a_d    = rf_rd1;
    b_d    = rf_rd2;
    held_d = alu_y;
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      ir_q    <= '0;
      epc_q   <= '0;
      cause_q <= 1'b0;
    end else begin
      pc_q    <= pc_d;
      ir_q    <= ir_d;
      epc_q   <= epc_d;
      cause_q <= cause_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdr_q  <= '0;
      a_q    <= '0;
      b_q    <= '0;
      held_q <= '0;
    end else begin
      mdr_q  <= mdr_d;
      a_q    <= a_d;
      b_q    <= b_d;
      held_q <= held_d;
    end
  end

  // ---------------- outputs ----------------
  assign mem_addr  = ctl_iord ? held_q : pc_q;
  assign mem_wdata = b_q;
  assign mem_rd_en = ctl_mem_rd;
  assign mem_wr_en = ctl_mem_wr;
  assign opcode    = ir_q[31:26];
  assign epc       = epc_q;
  assign cause     = {{(DW-1){1'b0}}, cause_q};

  // ---------------- assertions ----------------
  // R3
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_pc_we && !(ctl_pc_we_cond && alu_zero)) |=> $stable(pc_q));

  // R7
  ir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_ir_we |=> $stable(opcode));

  // R6
  exc_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_pc_we && ctl_pc_sel == PCS_EXC) |=> (mem_addr == EXC_VECTOR || ctl_iord));

  // R6
  cause_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_cause_we |=> cause == {{(DW-1){1'b0}}, $past(int_cause)});

  // R10
  ovf_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alu_ovf |-> (ctl_aluop != AOP_FUNC || ir_q[5:0] == FN_ADD || ir_q[5:0] == FN_SUB));

endmodule

// File: tb/mc_datapath_tb.sv
`timescale 1ns/1ps
module mc_datapath_tb;

  typedef struct packed {
    logic       iord, mrd, mwr, irwe, pcwe, pccond, rfwe, rfdst, rfsrc, srca;
    logic [1:0] srcb, aluop, pcsel;
    logic       epcwe, causewe, icause;
  } cw_t;

  localparam cw_t IDLE   = '{default:'0};
  localparam cw_t FETCH  = '{mrd:1'b1, irwe:1'b1, pcwe:1'b1, srcb:2'b01, default:'0};
  localparam cw_t DECODE = '{srcb:2'b11, default:'0};
  localparam cw_t MADDR  = '{srca:1'b1, srcb:2'b10, default:'0};
  localparam cw_t LWRD   = '{mrd:1'b1, iord:1'b1, default:'0};
  localparam cw_t LWWB   = '{rfwe:1'b1, rfsrc:1'b1, default:'0};
  localparam cw_t SWWR   = '{mwr:1'b1, iord:1'b1, default:'0};
  localparam cw_t RTEX   = '{srca:1'b1, aluop:2'b10, default:'0};
  localparam cw_t RTWB   = '{rfwe:1'b1, rfdst:1'b1, default:'0};
  localparam cw_t BEQ    = '{srca:1'b1, aluop:2'b01, pccond:1'b1, pcsel:2'b01, default:'0};
  localparam cw_t JUMP   = '{pcwe:1'b1, pcsel:2'b10, default:'0};
  localparam cw_t PEEK   = '{mrd:1'b1, default:'0};
  localparam cw_t EXC1   = '{srcb:2'b01, aluop:2'b01, epcwe:1'b1, causewe:1'b1, icause:1'b1,
                             pcwe:1'b1, pcsel:2'b11, default:'0};
  localparam cw_t EXC0   = '{srcb:2'b01, aluop:2'b01, epcwe:1'b1, causewe:1'b1, icause:1'b0,
                             pcwe:1'b1, pcsel:2'b11, default:'0};

  // {funct, a, b, expected, overflow}
  localparam int NV = 11;
  localparam logic [102:0] VECS [NV] = '{
    {6'b100000, 32'd5,          32'd7,          32'd12,         1'b0},
    {6'b100000, 32'h7FFF_FFFF,  32'd1,          32'h8000_0000,  1'b1},
    {6'b100010, 32'd10,         32'd10,         32'd0,          1'b0},
    {6'b100010, 32'h8000_0000,  32'd1,          32'h7FFF_FFFF,  1'b1},
    {6'b100100, 32'hF0F0_F0F0,  32'hFF00_FF00,  32'hF000_F000,  1'b0},
    {6'b100101, 32'hF0F0_F0F0,  32'h0F0F_0000,  32'hFFFF_F0F0,  1'b0},
    {6'b101010, 32'hFFFF_FFFF,  32'd1,          32'd1,          1'b0},
    {6'b101010, 32'd1,          32'hFFFF_FFFF,  32'd0,          1'b0},
    {6'b101010, 32'h8000_0000,  32'h7FFF_FFFF,  32'd1,          1'b0},
    {6'b000000, 32'd3,          32'd4,          32'd0,          1'b0},
    {6'b100000, 32'hFFFF_FFFF,  32'd1,          32'd0,          1'b0}
  };

  logic clk = 1'b0;
  logic rst_n;
  cw_t  cw;
  logic [31:0] mem_rdata, mem_addr, mem_wdata, epc, cause;
  logic mem_rd_en, mem_wr_en, alu_zero, alu_ovf;
  logic [5:0] opcode;
  logic [31:0] mem [256];
  logic [31:0] pc_m;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  mc_datapath u_dut (
    .clk(clk), .rst_n(rst_n),
    .ctl_iord(cw.iord), .ctl_mem_rd(cw.mrd), .ctl_mem_wr(cw.mwr), .ctl_ir_we(cw.irwe),
    .ctl_pc_we(cw.pcwe), .ctl_pc_we_cond(cw.pccond), .ctl_rf_we(cw.rfwe),
    .ctl_rf_dst(cw.rfdst), .ctl_rf_src(cw.rfsrc), .ctl_srca(cw.srca),
    .ctl_srcb(cw.srcb), .ctl_aluop(cw.aluop), .ctl_pc_sel(cw.pcsel),
    .ctl_epc_we(cw.epcwe), .ctl_cause_we(cw.causewe), .int_cause(cw.icause),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .opcode(opcode),
    .alu_zero(alu_zero), .alu_ovf(alu_ovf), .epc(epc), .cause(cause)
  );

  // word-addressed memory model, write on clock edge
  assign mem_rdata = mem_rd_en ? mem[mem_addr[9:2]] : 32'h0;
  always @(posedge clk) if (mem_wr_en) mem[mem_addr[9:2]] <= mem_wdata;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input cw_t c);
    @(posedge clk);
    #1;
    cw = c;
    #1.5;
  endtask

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt,
                                        input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic fetch(input logic [31:0] word);
    mem[pc_m[9:2]] <= word;
    apply(FETCH);
    chk("R2 fetch address is PC", mem_addr, pc_m);
    pc_m = pc_m + 4;
    apply(DECODE);
    chk("R7 opcode after fetch", 32'(opcode), 32'(word[31:26]));
  endtask

  task automatic do_lw(input int rs, input int rt, input logic [15:0] off, input logic [31:0] ea);
    fetch(enc_i(6'b100011, rs, rt, off));
    apply(MADDR);
    apply(LWRD);
    chk("R12 load effective address", mem_addr, ea);
    apply(LWWB);
  endtask

  task automatic do_sw(input int rs, input int rt, input logic [15:0] off, input logic [31:0] ea,
                       input logic [31:0] data, input string req);
    fetch(enc_i(6'b101011, rs, rt, off));
    apply(MADDR);
    apply(SWWR);
    chk("R2 store address from held result", mem_addr, ea);
    chk(req, mem_wdata, data);
  endtask

  task automatic do_r(input int rs, input int rt, input int rd, input logic [5:0] fn,
                      input logic ovf, input logic zero);
    fetch({6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'b00000, fn});
    apply(RTEX);
    chk("R10 overflow flag", 32'(alu_ovf), 32'(ovf));
    chk("R10 zero flag", 32'(alu_zero), 32'(zero));
    apply(RTWB);
  endtask

  task automatic do_j(input logic [25:0] tgt);
    fetch({6'b000010, tgt});
    apply(JUMP);
    pc_m = {pc_m[31:28], tgt, 2'b00};
    apply(IDLE);
    chk("R5 jump target splice", mem_addr, pc_m);
  endtask

  task automatic do_beq(input int rs, input int rt, input logic [15:0] off, input logic taken);
    fetch(enc_i(6'b000100, rs, rt, off));
    apply(BEQ);
    if (taken) pc_m = pc_m + {{14{off[15]}}, off, 2'b00};
    apply(IDLE);
    chk(taken ? "R4 branch taken" : "R4 branch not taken, R3 PC held", mem_addr, pc_m);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cw = IDLE;
    rst_n = 1'b0;
    pc_m = 32'h0;
    for (int i = 0; i < 256; i++) mem[i] <= 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset PC on address", mem_addr, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 opcode after reset", 32'(opcode), 32'h0);
    chk("R1 EPC after reset", epc, 32'h0);
    chk("R1 Cause after reset", cause, 32'h0);
    chk("R1 PC after release", mem_addr, 32'h0);

    // vector table: load two operands, operate, store, jump back to 0
    for (int v = 0; v < NV; v++) begin
      logic [5:0]  fn;
      logic [31:0] va, vb, ve;
      logic        vo;
      {fn, va, vb, ve, vo} = VECS[v];
      mem[200] <= va;
      mem[201] <= vb;
      do_lw(0, 1, 16'd800, 32'd800);
      do_lw(0, 2, 16'd804, 32'd804);
      do_r(1, 2, 3, fn, vo, ve == 32'h0);
      do_sw(0, 3, 16'd808, 32'd808, ve, "R9 ALU result via rd and store");
      do_j(26'h0);
      chk("R8 stored word in memory", mem[202], ve);
    end

    // R11: write to register 0 is dropped, reads back zero
    mem[200] <= 32'h0000_0055;
    do_lw(0, 0, 16'd800, 32'd800);
    do_sw(0, 0, 16'd808, 32'd808, 32'h0, "R11 register 0 reads zero");

    // R12 / R8: negative offset from a base register, load data path
    mem[203] <= 32'h0000_0340;
    mem[200] <= 32'h0000_ABCD;
    do_lw(0, 5, 16'd812, 32'd812);
    do_lw(5, 6, 16'hFFE0, 32'd800);
    do_sw(0, 6, 16'd808, 32'd808, 32'h0000_ABCD, "R8 load data written to rt");

    // R7: memory read without IR write leaves opcode alone
    mem[pc_m[9:2]] <= enc_i(6'b100011, 0, 0, 16'h0);
    apply(FETCH);
    pc_m = pc_m + 4;
    mem[pc_m[9:2]] <= 32'hFC00_0000;
    apply(PEEK);
    apply(IDLE);
    chk("R7 IR held without write enable", 32'(opcode), 32'h23);
    chk("R3 PC held without write", mem_addr, pc_m);

    // R4: registers r1=FFFFFFFF, r2=1 from the last vector
    do_beq(1, 2, 16'hFFFE, 1'b0);
    do_beq(1, 1, 16'd3, 1'b1);

    // R6: overflow exception
    fetch(32'hFC00_0000);
    apply(EXC1);
    apply(IDLE);
    chk("R6 EPC points at faulting word", epc, pc_m - 4);
    chk("R6 Cause overflow code", cause, 32'h1);
    chk("R6 exception vector", mem_addr, 32'hC000_0000);
    pc_m = 32'hC000_0000;

    // R5: jump keeps upper PC bits
    do_j(26'h5);
    chk("R5 upper nibble kept", mem_addr, 32'hC000_0014);

    // R6: second exception, undefined instruction code
    apply(EXC0);
    apply(IDLE);
    chk("R6 EPC second exception", epc, 32'hC000_0010);
    chk("R6 Cause undefined code", cause, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule